// File: doc/BRIEF.md
# False Carrier Port Isolation

This block watches one port of a 100 Mbps repeater and sorts each carrier event by the first two code-groups that arrive. A proper frame opens with the J/K start-of-stream delimiter. Any event that opens with something else is a false carrier. When a port produces more false carriers in a row than a set limit, the block isolates the port. It also raises a latched interrupt and keeps a saturating count of false carriers that clears when software reads it.

Symbol decoding happens upstream. It delivers a one-cycle `carrierStart` strobe and, in the same cycle, a `sdValid` flag that tells whether J/K was seen. The port speed input gates the whole function, because isolation applies only at 100 Mbps. The `readClr` strobe stands for a read of the status. It clears the false-carrier count and both latched flags.

Top module: `fc_isolate`

## Requirements
- R1: After reset, `isolated`, `fcCount`, `isoIrq` and `fcHighIrq` are all 0.
- R2: A false carrier is a cycle with `carrierStart`=1 and `sdValid`=0 while `speed100`=1. On the next cycle it raises `fcCount` by one. The count saturates at 2^CNT_W-1, which is 15 by default.
- R3: A valid event is a cycle with `carrierStart`=1 and `sdValid`=1 at 100 Mbps. It leaves `fcCount` unchanged and resets the run of consecutive false carriers to zero.
- R4: A false carrier that makes the run exceed ISO_LIMIT (default 2, so the third in a row) sets `isolated` on the next cycle. Two false carriers, then a valid event, then two more false carriers do not isolate the port.
- R5: Entering isolation sets `isoIrq`. The flag stays set, even after the port leaves isolation, until `readClr`.
- R6: While the port is isolated, a valid event clears `isolated` on the next cycle. Further false carriers keep the port isolated.
- R7: While `speed100`=0, carrier events change nothing. `isolated` falls on the cycle after `speed100` goes low, and the run of consecutive false carriers is cleared.
- R8: `fcHighIrq` is set when a false carrier brings `fcCount` to FC_HIGH (default 8) or above. It is held until `readClr`.
- R9: `readClr` clears `fcCount`, `isoIrq` and `fcHighIrq` on the next cycle and leaves `isolated` unchanged. A false carrier in the same cycle as `readClr` leaves `fcCount`=1.
- R10: `sdValid` has no effect when `carrierStart`=0. In particular, it does not reset the run of false carriers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| carrierStart | input | 1 | One-cycle strobe at the start of a carrier event |
| sdValid | input | 1 | Event began with J/K (valid with carrierStart) |
| speed100 | input | 1 | 1 when the port runs at 100 Mbps |
| readClr | input | 1 | Status read strobe; clears count and flags |
| isolated | output | 1 | Port is isolated |
| fcCount | output | CNT_W | Saturating false-carrier count since last read |
| isoIrq | output | 1 | Latched isolation interrupt |
| fcHighIrq | output | 1 | Latched excessive-false-carrier interrupt |

## Verification
Every result is registered once, so each output reflects a stimulus exactly one clock edge after the strobe was sampled. The bench drives a one-cycle strobe on a falling edge and drops it on the next falling edge. The rising edge in between captures the strobe, so the bench compares outputs at that second falling edge and never at an edge. A sweep over all 64 sequences of six valid or false events checks count, isolation and interrupt after every event against an arithmetic model. Directed sequences then cover saturation, the threshold flag, reads, speed loss and a stray `sdValid`.

// File: rtl/fciso_pkg.sv
package fciso_pkg;
  typedef struct packed {
    logic countFalse;
    logic clearRun;
    logic clearCount;
    logic setIsoIrq;
  } fcStrobe_t;

  typedef enum logic {
    PORT_NORMAL   = 1'b0,
    PORT_ISOLATED = 1'b1
  } portState_t;
endpackage

// File: rtl/fciso_ctl.sv
module fciso_ctl
  import fciso_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      carrierStart,
  input  logic      sdValid,
  input  logic      speed100,
  input  logic      readClr,
  input  logic      runAtLimit,
  output fcStrobe_t strb,
  output logic      isolated
);
  portState_t state, stateNext;
  logic falseEvt, validEvt;

  assign falseEvt = carrierStart && !sdValid && speed100;
  assign validEvt = carrierStart && sdValid && speed100;

  always_comb begin
    strb.countFalse = falseEvt;
    strb.clearRun   = validEvt || !speed100;
    strb.clearCount = readClr;
    strb.setIsoIrq  = (state == PORT_NORMAL) && falseEvt && runAtLimit;
  end

  always_comb begin
    stateNext = state;
    case (state)
      PORT_NORMAL:   if (strb.setIsoIrq) stateNext = PORT_ISOLATED;
      PORT_ISOLATED: if (!speed100 || validEvt) stateNext = PORT_NORMAL;
      default:       stateNext = PORT_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PORT_NORMAL;
    else       state <= stateNext;
  end

  assign isolated = (state == PORT_ISOLATED);

  // R7
  speed_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isolated && !speed100) |=> !isolated);
  // R4
  iso_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isolated && speed100 && carrierStart && !sdValid && runAtLimit) |=> isolated);
  // R6
  iso_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isolated && speed100 && carrierStart && sdValid) |=> !isolated);
endmodule

// File: rtl/fciso_dp.sv
module fciso_dp
  import fciso_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int ISO_LIMIT = 2,
  parameter int FC_HIGH   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcStrobe_t        strb,
  output logic             runAtLimit,
  output logic [CNT_W-1:0] fcCount,
  output logic             isoIrq,
  output logic             fcHighIrq
);
  localparam int RUN_MAX = ISO_LIMIT + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [RUN_W-1:0] runLen;
  logic [CNT_W-1:0] countNext;

  always_ff @(posedge clk) begin
    if (!rstN)                 runLen <= '0;
    else if (strb.clearRun)    runLen <= '0;
    else if (strb.countFalse && runLen != RUN_W'(RUN_MAX))
                               runLen <= runLen + 1'b1;
  end

  assign runAtLimit = (runLen >= RUN_W'(ISO_LIMIT));

  always_comb begin
    if (strb.clearCount)
      countNext = strb.countFalse ? CNT_W'(1) : '0;
    else if (strb.countFalse && fcCount != CNT_MAX)
      countNext = fcCount + 1'b1;
    else
      countNext = fcCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fcCount   <= '0;
      isoIrq    <= 1'b0;
      fcHighIrq <= 1'b0;
    end else begin
      fcCount <= countNext;
      if (strb.setIsoIrq)       isoIrq <= 1'b1;
      else if (strb.clearCount) isoIrq <= 1'b0;
      if (strb.countFalse && countNext >= CNT_W'(FC_HIGH)) fcHighIrq <= 1'b1;
      else if (strb.clearCount)                            fcHighIrq <= 1'b0;
    end
  end

  // R2
  count_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearCount |=> fcCount >= $past(fcCount));
  // R2
  count_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fcCount == CNT_MAX && !strb.clearCount) |=> fcCount == CNT_MAX);
  // R5
  iso_irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isoIrq && !strb.clearCount) |=> isoIrq);
  // R8
  high_irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fcHighIrq && !strb.clearCount) |=> fcHighIrq);
endmodule

// File: rtl/fc_isolate.sv
module fc_isolate
  import fciso_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int ISO_LIMIT = 2,
  parameter int FC_HIGH   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             carrierStart,
  input  logic             sdValid,
  input  logic             speed100,
  input  logic             readClr,
  output logic             isolated,
  output logic [CNT_W-1:0] fcCount,
  output logic             isoIrq,
  output logic             fcHighIrq
);
  fcStrobe_t strb;
  logic      runAtLimit;

  fciso_ctl u_ctl (
    .clk(clk), .rstN(rstN), .carrierStart(carrierStart), .sdValid(sdValid),
    .speed100(speed100), .readClr(readClr), .runAtLimit(runAtLimit),
    .strb(strb), .isolated(isolated)
  );

  fciso_dp #(.CNT_W(CNT_W), .ISO_LIMIT(ISO_LIMIT), .FC_HIGH(FC_HIGH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .runAtLimit(runAtLimit),
    .fcCount(fcCount), .isoIrq(isoIrq), .fcHighIrq(fcHighIrq)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!isolated && fcCount == '0 && !isoIrq && !fcHighIrq));
endmodule

// File: tb/sim_fc_isolate.sv
module sim_fc_isolate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic carrierStart = 1'b0, sdValid = 1'b0, speed100 = 1'b1, readClr = 1'b0;
  logic isolated, isoIrq, fcHighIrq;
  logic [3:0] fcCount;
  int checks = 0, failures = 0;
  int mRun, mCnt;
  bit mIso, mIsoIrq, mHi;

  always #4 clk = ~clk;

  fc_isolate u0 (
    .clk(clk), .rstN(rstN), .carrierStart(carrierStart), .sdValid(sdValid),
    .speed100(speed100), .readClr(readClr), .isolated(isolated),
    .fcCount(fcCount), .isoIrq(isoIrq), .fcHighIrq(fcHighIrq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    mRun = 0; mCnt = 0; mIso = 0; mIsoIrq = 0; mHi = 0;
  endtask

  // one-cycle strobe; outputs compared at the following falling edge
  task automatic evt(bit valid, bit rd);
    @(negedge clk);
    carrierStart = 1'b1; sdValid = valid; readClr = rd;
    @(negedge clk);
    carrierStart = 1'b0; sdValid = 1'b0; readClr = 1'b0;
    if (rd) begin mCnt = 0; mIsoIrq = 0; mHi = 0; end
    if (!valid) begin
      if (mCnt < 15) mCnt++;
      if (mCnt >= 8) mHi = 1;
      mRun++;
      if (!mIso && mRun > 2) begin mIso = 1; mIsoIrq = 1; end
    end else begin
      mRun = 0; mIso = 0;
    end
  endtask

  task automatic cmpAll(string req);
    chk({req, " count"}, fcCount, mCnt);
    chk({req, " isolated"}, isolated, mIso);
    chk({req, " isoIrq"}, isoIrq, mIsoIrq);
    chk({req, " highIrq"}, fcHighIrq, mHi);
  endtask

  initial begin
    #1_200_000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    cmpAll("R1");

    // R2 R3 R4 R6: every sequence of six valid/false events
    for (int p = 0; p < 64; p++) begin
      doReset();
      for (int k = 0; k < 6; k++) begin
        evt(p[k], 1'b0);
        cmpAll("R4");
      end
    end

    // R4: two false, valid, two false -> not isolated
    doReset();
    evt(0,0); evt(0,0); evt(1,0); evt(0,0); evt(0,0);
    chk("R4 no isolation after break", isolated, 0);
    chk("R3 valid leaves count", fcCount, 4);

    // R10: stray sdValid without carrierStart keeps the run
    @(negedge clk); sdValid = 1'b1;
    @(negedge clk); sdValid = 1'b0;
    chk("R10 count unchanged", fcCount, 4);
    evt(0,0);
    chk("R10 run kept, third false isolates", isolated, 1);

    // R5: flag held after leaving isolation
    evt(1,0);
    chk("R6 valid exits isolation", isolated, 0);
    repeat (3) @(negedge clk);
    chk("R5 isoIrq held", isoIrq, 1);

    // R8 and R2 saturation
    doReset();
    for (int i = 1; i <= 7; i++) evt(0,0);
    chk("R8 below threshold", fcHighIrq, 0);
    chk("R6 false keeps isolated", isolated, 1);
    evt(0,0);
    chk("R8 at threshold", fcHighIrq, 1);
    chk("R2 count 8", fcCount, 8);
    for (int i = 0; i < 10; i++) evt(0,0);
    chk("R2 saturates", fcCount, 15);

    // R9: read clears count and flags, isolation unchanged
    @(negedge clk); readClr = 1'b1;
    @(negedge clk); readClr = 1'b0;
    chk("R9 count cleared", fcCount, 0);
    chk("R9 isoIrq cleared", isoIrq, 0);
    chk("R9 highIrq cleared", fcHighIrq, 0);
    chk("R9 isolation kept", isolated, 1);
    mCnt = 0; mIsoIrq = 0; mHi = 0;
    evt(0,1);
    chk("R9 read with false", fcCount, 1);

    // R7: speed loss
    @(negedge clk); speed100 = 1'b0;
    @(negedge clk);
    chk("R7 isolation drops", isolated, 0);
    @(negedge clk); carrierStart = 1'b1; sdValid = 1'b0;
    @(negedge clk); carrierStart = 1'b0;
    chk("R7 event ignored", fcCount, 1);
    chk("R7 no isolation", isolated, 0);
    speed100 = 1'b1;
    mRun = 0; mIso = 0;
    evt(0,0);
    chk("R7 run cleared", isolated, 0);
    chk("R7 counting resumes", fcCount, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule